// File: doc/BRIEF.md
# Pushbutton and Power-Fail Reset Line Controller

This block owns one active-low, open-drain reset line that doubles as a pushbutton input. While nothing else is going on it watches the sensed level of the line. A falling edge, meaning a press, makes the block pull the line low itself for a debounce time. After that time it lets go and looks at the line again. If the line is still held low, the block waits for the button to be released. Release then starts a reset pulse of fixed length, which the block drives.

A digital power-fail input overrides all of this. While it is asserted the line is pulled low. When it clears, the line stays low for a recovery time, so that the supply can settle. That delay is skipped when the oscillator-running input is low. All long timers count pulses of a slow tick input. The surrounding logic sees only the line, so asserting reset does not disturb it.

Top module: `resetline_ctrl`

## Requirements
- R1: After synchronous reset the block does not pull the line (`line_pull_low` = 0, where 1 means pull low) and it waits for a press.
- R2: A falling edge of the synchronized line while idle makes the block pull the line low for `DEBOUNCE_TICKS` tick pulses.
- R3: When debounce ends the block releases the line for `SETTLE_CYCLES` clock cycles and then samples it. If the line is high it goes back to idle and no reset pulse follows.
- R4: If the sampled line is low, the block leaves the line released and waits for a rising edge.
- R5: A rising edge while waiting makes the block pull the line low for `PULSE_TICKS` tick pulses and then release it.
- R6: While the synchronized power-fail input is high the line is pulled low. This has priority over the pushbutton sequence and cancels it. A button that is still held when power returns does not start a new sequence.
- R7: When power-fail clears and the oscillator is running, the line stays low for `RECOVER_TICKS` tick pulses.
- R8: When power-fail clears and the oscillator is not running, the line is released at once.
- R9: If power-fail asserts again during recovery, the line stays low, and the recovery time starts again when it clears.
- R10: A press that starts while the block is driving a reset pulse has no effect. If the button is still held when the pulse ends, no debounce follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse of the slow timer tick (nominally 1 kHz) |
| line_in | input | 1 | Sensed level of the shared reset line (asynchronous) |
| power_fail | input | 1 | High while the supply is below threshold (asynchronous) |
| osc_running | input | 1 | High when the oscillator is running (asynchronous) |
| line_pull_low | output | 1 | 1 pulls the open-drain line low, 0 releases it |

## Verification
The bench models an open-drain wire: the line is low when the block pulls it or when the button is pressed. The block is tried with several button patterns. A short tap separates the return to idle after debounce from a held press. A long hold followed by release shows the wait for release and the pulse that follows it. A second press during the pulse shows that input is ignored while the block drives the line. Power-fail is applied in the middle of a debounce, reapplied during recovery, and applied again with the oscillator stopped. These cases separate the priority of power-fail, the restart of recovery and the skipped delay.

// File: rtl/resetline_pkg.sv
// Shared types for the reset line controller.
// Assumes: consumed by every module of the block via import.
package resetline_pkg;

    // Sequencer states for the shared reset line.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DEBOUNCE = 3'd1,
        ST_SETTLE   = 3'd2,
        ST_WAIT_REL = 3'd3,
        ST_PULSE    = 3'd4,
        ST_PFAIL    = 3'd5,
        ST_RECOVER  = 3'd6
    } rl_state_e;

endpackage

// File: rtl/resetline_sync.sv
// Multi-stage flip-flop synchronizer for a vector of asynchronous levels.
// Assumes: each bit is a slow level and is synchronized on its own; no
// bit-to-bit coherence is needed. RESET_VAL gives the idle level of each bit.
module resetline_sync #(
    parameter int                 WIDTH     = 1,
    parameter int                 STAGES    = 2,
    parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= RESET_VAL;
                    else        stage[0] <= d;
                end
            end else begin : g_next
                // Shift the value one stage further along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[s] <= RESET_VAL;
                    else        stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/resetline_timer.sv
// Shared interval counter. It counts step pulses from zero and reports done
// on the step that completes LIMIT steps.
// Assumes: the sequencer clears it on every state change and LIMIT >= 1.
module resetline_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic          done
);

    logic [CW-1:0] count;

    // Clear on request, otherwise advance on each step pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (clear)  count <= '0;
        else if (step)   count <= count + CW'(1);
    end

    // Terminal step: the step that brings the total to LIMIT.
    always_comb begin
        done = step && (count == (limit - CW'(1)));
    end

endmodule

// File: rtl/resetline_fsm.sv
// Sequencer for the shared reset line. It handles the pushbutton debounce,
// the wait for release and the reset pulse, with power-fail handling and
// its recovery delay taking priority over all of them.
// Assumes: all level inputs are already synchronized; tick is a one-cycle
// pulse in the clk domain; limits are at least 1.
module resetline_fsm
    import resetline_pkg::*;
#(
    parameter int CW             = 8,
    parameter int DEBOUNCE_TICKS = 250,
    parameter int PULSE_TICKS    = 250,
    parameter int RECOVER_TICKS  = 250,
    parameter int SETTLE_CYCLES  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line_s,
    input  logic          line_fall,
    input  logic          line_rise,
    input  logic          pf_s,
    input  logic          osc_s,
    input  logic          timer_done,
    output logic          timer_clear,
    output logic          timer_step,
    output logic [CW-1:0] timer_limit,
    output rl_state_e     state,
    output logic          pull_low
);

    localparam logic [CW-1:0] LIM_DEB = CW'(DEBOUNCE_TICKS);
    localparam logic [CW-1:0] LIM_PUL = CW'(PULSE_TICKS);
    localparam logic [CW-1:0] LIM_REC = CW'(RECOVER_TICKS);
    localparam logic [CW-1:0] LIM_SET = CW'(SETTLE_CYCLES);

    rl_state_e state_n;

    // Next-state choice; power-fail overrides every other condition.
    always_comb begin
        state_n = state;
        if (pf_s) begin
            state_n = ST_PFAIL;
        end else begin
            unique case (state)
                ST_IDLE:     if (line_fall)  state_n = ST_DEBOUNCE;
                ST_DEBOUNCE: if (timer_done) state_n = ST_SETTLE;
                ST_SETTLE:   if (timer_done) state_n = line_s ? ST_IDLE : ST_WAIT_REL;
                ST_WAIT_REL: if (line_rise)  state_n = ST_PULSE;
                ST_PULSE:    if (timer_done) state_n = ST_IDLE;
                ST_PFAIL:    state_n = osc_s ? ST_RECOVER : ST_IDLE;
                ST_RECOVER:  if (timer_done) state_n = ST_IDLE;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Timer control: tick-based intervals, and the settle gap in clock cycles.
    always_comb begin
        timer_clear = (state_n != state);
        timer_step  = 1'b0;
        timer_limit = LIM_DEB;
        unique case (state)
            ST_DEBOUNCE: begin timer_step = tick; timer_limit = LIM_DEB; end
            ST_SETTLE:   begin timer_step = 1'b1; timer_limit = LIM_SET; end
            ST_PULSE:    begin timer_step = tick; timer_limit = LIM_PUL; end
            ST_RECOVER:  begin timer_step = tick; timer_limit = LIM_REC; end
            default:     begin timer_step = 1'b0; timer_limit = LIM_DEB; end
        endcase
    end

    // Line driver decode: pull low in every driven phase.
    always_comb begin
        unique case (state)
            ST_DEBOUNCE, ST_PULSE, ST_PFAIL, ST_RECOVER: pull_low = 1'b1;
            default:                                     pull_low = 1'b0;
        endcase
    end

endmodule

// File: rtl/resetline_ctrl.sv
// Top of the reset line controller. It synchronizes the sensed line, the
// power-fail input and the oscillator status, detects edges on the line,
// and connects the sequencer to the shared interval timer.
// Assumes: line_in is the wired level of the open-drain line, and it includes
// this block's own pull-down. SETTLE_CYCLES covers the synchronizer
// latency (at least SYNC_STAGES + 2).
module resetline_ctrl
    import resetline_pkg::*;
#(
    parameter int DEBOUNCE_TICKS = 250,
    parameter int PULSE_TICKS    = 250,
    parameter int RECOVER_TICKS  = 250,
    parameter int SETTLE_CYCLES  = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_in,
    input  logic power_fail,
    input  logic osc_running,
    output logic line_pull_low
);

    localparam int MAX_AB  = (DEBOUNCE_TICKS > PULSE_TICKS) ? DEBOUNCE_TICKS : PULSE_TICKS;
    localparam int MAX_ABC = (MAX_AB > RECOVER_TICKS) ? MAX_AB : RECOVER_TICKS;
    localparam int MAX_LIM = (MAX_ABC > SETTLE_CYCLES) ? MAX_ABC : SETTLE_CYCLES;
    localparam int CW      = $clog2(MAX_LIM + 1);

    logic          line_s;
    logic          line_q;
    logic          line_fall;
    logic          line_rise;
    logic [1:0]    status_s;
    logic          pf_s;
    logic          osc_s;
    logic          timer_clear;
    logic          timer_step;
    logic          timer_done;
    logic [CW-1:0] timer_limit;
    rl_state_e     state;

    resetline_sync #(
        .WIDTH     (1),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_line_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    resetline_sync #(
        .WIDTH     (2),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (2'b00)
    ) u_status_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({power_fail, osc_running}),
        .q     (status_s)
    );

    assign pf_s  = status_s[1];
    assign osc_s = status_s[0];

    // Keep the previous synchronized line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line_s;
    end

    assign line_fall = line_q & ~line_s;
    assign line_rise = ~line_q & line_s;

    resetline_timer #(
        .CW (CW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .step  (timer_step),
        .limit (timer_limit),
        .done  (timer_done)
    );

    resetline_fsm #(
        .CW             (CW),
        .DEBOUNCE_TICKS (DEBOUNCE_TICKS),
        .PULSE_TICKS    (PULSE_TICKS),
        .RECOVER_TICKS  (RECOVER_TICKS),
        .SETTLE_CYCLES  (SETTLE_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .line_s      (line_s),
        .line_fall   (line_fall),
        .line_rise   (line_rise),
        .pf_s        (pf_s),
        .osc_s       (osc_s),
        .timer_done  (timer_done),
        .timer_clear (timer_clear),
        .timer_step  (timer_step),
        .timer_limit (timer_limit),
        .state       (state),
        .pull_low    (line_pull_low)
    );

endmodule

// File: rtl/resetline_ctrl_chk.sv
// Assertion checker for the reset line controller. It relates the
// sequencer state and the synchronized inputs to the line driver one cycle
// later.
// Assumes: attached to resetline_ctrl by the bind below.
module resetline_ctrl_chk
    import resetline_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input rl_state_e state,
    input logic      pf_s,
    input logic      osc_s,
    input logic      line_fall,
    input logic      line_rise,
    input logic      line_pull_low
);

    // R2: a press seen in idle starts the driven debounce.
    assert_press_debounce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && line_fall && !pf_s) |=> line_pull_low);

    // R4: while waiting for release the line stays released.
    assert_wait_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_REL && !line_rise && !pf_s) |=> !line_pull_low);

    // R5: release while waiting starts the driven reset pulse.
    assert_release_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_REL && line_rise && !pf_s) |=> line_pull_low);

    // R6: synchronized power-fail pulls the line on the next cycle.
    assert_pfail_pulls_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_s |=> line_pull_low);

    // R7: power return with a running oscillator keeps the line low.
    assert_recover_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PFAIL && !pf_s && osc_s) |=> line_pull_low);

    // R8: power return with a stopped oscillator releases at once.
    assert_recover_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PFAIL && !pf_s && !osc_s) |=> !line_pull_low);

endmodule

bind resetline_ctrl resetline_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .pf_s          (pf_s),
    .osc_s         (osc_s),
    .line_fall     (line_fall),
    .line_rise     (line_rise),
    .line_pull_low (line_pull_low)
);

// File: tb/resetline_ctrl_test.sv
// Bench for resetline_ctrl: an open-drain wire model, a behavioural
// cycle-by-cycle reference compared on every clock, plus scenario checks.
module resetline_ctrl_test;

    localparam int DEB = 5;
    localparam int PUL = 4;
    localparam int REC = 6;
    localparam int SET = 4;
    localparam int TDIV = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic power_fail = 1'b0;
    logic osc_running = 1'b0;
    logic button = 1'b0;
    logic line_pull_low;
    wire  line_in = !(line_pull_low || button);

    // Stimulus requested by the scenario script, applied at the next negedge.
    logic rst_r = 1'b0;
    logic btn_r = 1'b0;
    logic pf_r = 1'b0;
    logic osc_r = 1'b0;

    int tests = 0;
    int fails = 0;
    int low_count = 0;
    int tdiv = 0;
    bit finished = 1'b0;

    // Reference model state (0 idle,1 debounce,2 settle,3 wait,4 pulse,5 pfail,6 recover).
    int m_state = 0;
    int m_cnt = 0;
    bit m_l1 = 1'b1, m_l2 = 1'b1, m_lq = 1'b1;
    bit m_p1 = 1'b0, m_p2 = 1'b0;
    bit m_o1 = 1'b0, m_o2 = 1'b0;

    always #2.5 clk = ~clk;

    resetline_ctrl #(
        .DEBOUNCE_TICKS (DEB),
        .PULSE_TICKS    (PUL),
        .RECOVER_TICKS  (REC),
        .SETTLE_CYCLES  (SET),
        .SYNC_STAGES    (2)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .line_in       (line_in),
        .power_fail    (power_fail),
        .osc_running   (osc_running),
        .line_pull_low (line_pull_low)
    );

    function automatic bit m_drive(input int st);
        return (st == 1) || (st == 4) || (st == 5) || (st == 6);
    endfunction

    function automatic string tag_of(input int st);
        case (st)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the reference by one clock edge with the inputs just applied.
    task automatic model_step(input bit tk);
        bit pin, fall, rise, stp, done;
        int lim, nxt;
        if (!rst_r) begin
            m_state = 0; m_cnt = 0;
            m_l1 = 1; m_l2 = 1; m_lq = 1;
            m_p1 = 0; m_p2 = 0; m_o1 = 0; m_o2 = 0;
            return;
        end
        pin  = !(m_drive(m_state) || btn_r);
        fall = m_lq && !m_l2;
        rise = !m_lq && m_l2;
        stp  = (m_state == 2) ? 1'b1 : ((m_state == 1 || m_state == 4 || m_state == 6) ? tk : 1'b0);
        lim  = (m_state == 2) ? SET : (m_state == 4) ? PUL : (m_state == 6) ? REC : DEB;
        done = stp && (m_cnt == lim - 1);
        nxt  = m_state;
        if (m_p2) nxt = 5;
        else case (m_state)
            0: if (fall) nxt = 1;
            1: if (done) nxt = 2;
            2: if (done) nxt = m_l2 ? 0 : 3;
            3: if (rise) nxt = 4;
            4: if (done) nxt = 0;
            5: nxt = m_o2 ? 6 : 0;
            default: if (done) nxt = 0;
        endcase
        if (nxt != m_state) m_cnt = 0;
        else if (stp)       m_cnt = m_cnt + 1;
        m_state = nxt;
        m_lq = m_l2; m_l2 = m_l1; m_l1 = pin;
        m_p2 = m_p1; m_p1 = pf_r;
        m_o2 = m_o1; m_o1 = osc_r;
    endtask

    // Run n cycles: compare on the falling edge, then apply inputs and step the model.
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            bit tk;
            @(negedge clk);
            if (rst_r) begin
                check(line_pull_low === m_drive(m_state), tag_of(m_state),
                      int'(line_pull_low), int'(m_drive(m_state)));
                if (line_pull_low) low_count++;
            end
            tk = rst_r && (tdiv == TDIV - 1);
            tdiv = (!rst_r || tdiv == TDIV - 1) ? 0 : tdiv + 1;
            rst_n = rst_r; button = btn_r; power_fail = pf_r;
            osc_running = osc_r; tick = tk;
            model_step(tk);
        end
    endtask

    initial begin
        rst_r = 0; run(4);
        rst_r = 1; osc_r = 1; run(2);
        check(line_pull_low == 1'b0, "R1", int'(line_pull_low), 0);
        run(20);

        // Short tap: debounce, then the line reads high and no pulse follows.
        btn_r = 1; run(3); btn_r = 0; run(80);
        low_count = 0; run(30);
        check(low_count == 0, "R3", low_count, 0);

        // Long hold: wait released, then release starts the pulse.
        btn_r = 1; run(60);
        check(line_pull_low == 1'b0, "R4", int'(line_pull_low), 0);
        btn_r = 0; run(12);
        check(line_pull_low == 1'b1, "R5", int'(line_pull_low), 1);
        // New press during the pulse, held past its end, is ignored.
        btn_r = 1; run(60);
        low_count = 0; run(30);
        check(low_count == 0, "R10", low_count, 0);
        btn_r = 0; run(40);

        // Power-fail in the middle of a debounce, button still held.
        btn_r = 1; run(10);
        pf_r = 1; run(10);
        check(line_pull_low == 1'b1, "R6", int'(line_pull_low), 1);
        pf_r = 0; run(15);
        check(line_pull_low == 1'b1, "R7", int'(line_pull_low), 1);
        run(60); btn_r = 0; run(5);
        low_count = 0; run(40);
        check(low_count == 0, "R6", low_count, 0);

        // Power-fail reapplied during recovery restarts it.
        pf_r = 1; run(10); pf_r = 0; run(10);
        pf_r = 1; run(5);
        check(line_pull_low == 1'b1, "R9", int'(line_pull_low), 1);
        pf_r = 0; run(20);
        check(line_pull_low == 1'b1, "R9", int'(line_pull_low), 1);
        run(40);
        check(line_pull_low == 1'b0, "R7", int'(line_pull_low), 0);

        // Oscillator stopped: recovery is skipped.
        osc_r = 0; run(5);
        pf_r = 1; run(10); pf_r = 0; run(5);
        check(line_pull_low == 1'b0, "R8", int'(line_pull_low), 0);
        run(20);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule